// File: doc/BRIEF.md
# Windowed Watchdog with Locked Configuration

This block is a supervision timer for a processor subsystem. A 16-bit down-counter advances once per slow-clock enable pulse. Software must restart it before it runs out, but only once the count has fallen to or below a programmable window threshold. A restart that arrives too early is treated as a fault, just as running out is. This catches a program that is stuck in a tight loop which keeps servicing the timer.

Every register write must carry a fixed key in its top byte, or it is dropped. The configuration word holds the reload value, the window threshold, the interrupt and reset-request enables and a stop bit. It is accepted only once after reset, so code that has lost control cannot turn the watchdog off or widen its window. Faults are kept in sticky status bits that a read strobe clears. The status bits drive an interrupt output and a reset-request output, each gated by its enable. Reset sequencing itself lies outside this block.

Top module: `wwdt_top`

## Requirements
- R1: After reset the count is 0xFFFF, both status bits are 0, and irq and rst_req are 0. The default configuration is: reload 0xFFFF, window threshold 0xFFFF, interrupt disabled, reset request enabled, not stopped.
- R2: A write whose bits [42:35] are not 0xA5 changes nothing: neither the count, the configuration, the status nor the lock.
- R3: A keyed write to address 1 is accepted only while unlocked. Its field layout is reload [15:0], threshold [31:16], irq enable [32], reset-request enable [33] and stop [34]. The accepted write loads the count with the new reload on the following edge and locks the configuration. Every later write to address 1 is ignored, even one with the correct key.
- R4: Each tick decrements the count by one while the block is not stopped. A count of zero holds at zero.
- R5: A tick that moves the count from 1 to 0 sets the underflow status bit, stat[0].
- R6: A keyed write to address 0 with bit 0 set is a restart. If the count is above the threshold, the restart sets the error status bit, stat[1], and leaves the count unchanged.
- R7: A restart with the count at or below the threshold is held pending. The count reloads on the first tick in a later cycle, not on a tick in the same cycle as the restart.
- R8: irq equals (stat[0] or stat[1]) AND the irq enable. rst_req equals (stat[0] or stat[1]) AND the reset-request enable.
- R9: A stat_rd pulse clears both status bits on the next edge. A fault event in that same cycle wins, and its bit stays set.
- R10: When the stop bit is set, the count stays frozen, and restarts have no effect and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow-clock enable, one cycle per count step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = restart control, 1 = configuration |
| wr_data | input | 43 | Write word, key in bits [42:35] |
| stat_rd | input | 1 | Status read strobe, clears sticky bits |
| count | output | 16 | Current counter value |
| stat | output | 2 | {error, underflow} sticky bits |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |

## Verification
Restarts are issued at random points against random thresholds, so the bench separates restarts inside the window (a pending reload) from those above it (an error with the count left alone). Some restarts fall on the same cycle as a tick, which exposes whether a reload was applied too early. Keys, addresses and a second configuration write are mixed in to tell accepted writes apart from dropped ones. Reads that collide with an underflow tick show whether setting a status bit takes priority over clearing it.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
   localparam int unsigned KEY_W   = 8;
   localparam logic [KEY_W-1:0] KEY_VAL = 8'hA5;
   localparam int unsigned N_FLAGS = 3;

   typedef struct packed {
      logic stop;
      logic rst_en;
      logic irq_en;
   } wd_flags_t;

   typedef enum logic [1:0] {
      WA_CTRL = 2'd0,
      WA_MODE = 2'd1
   } wd_addr_e;
endpackage

// File: rtl/wwdt_regs.sv
module wwdt_regs
   import wwdt_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned ADDR_W     = 2,
   parameter logic [CNT_W-1:0] DEF_RELOAD = '1,
   parameter logic [CNT_W-1:0] DEF_DELTA  = '1,
   parameter wd_flags_t DEF_FLAGS = '{stop: 1'b0, rst_en: 1'b1, irq_en: 1'b0}
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [KEY_W+2*CNT_W+N_FLAGS-1:0]  wr_data,
   output logic [CNT_W-1:0]                  reload,
   output logic [CNT_W-1:0]                  delta,
   output wd_flags_t                         flags,
   output logic                              mode_load,
   output logic [CNT_W-1:0]                  new_reload,
   output logic                              restart_req
);
   localparam int unsigned WORD_W  = KEY_W + 2*CNT_W + N_FLAGS;
   localparam int unsigned FLAG_LO = 2*CNT_W;

   logic      key_ok;
   logic      locked_q;
   logic [CNT_W-1:0] reload_q, delta_q;
   wd_flags_t flags_q;

   assign key_ok      = (wr_data[WORD_W-1 -: KEY_W] == KEY_VAL);
   assign mode_load   = wr_en && key_ok && !locked_q && (wr_addr == ADDR_W'(WA_MODE));
   assign restart_req = wr_en && key_ok && wr_data[0] && !flags_q.stop
                        && (wr_addr == ADDR_W'(WA_CTRL));
   assign new_reload  = wr_data[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         reload_q <= DEF_RELOAD;
         delta_q  <= DEF_DELTA;
         flags_q  <= DEF_FLAGS;
      end else if (mode_load) begin
         locked_q <= 1'b1;
         reload_q <= wr_data[CNT_W-1:0];
         delta_q  <= wr_data[2*CNT_W-1:CNT_W];
         flags_q  <= wd_flags_t'(wr_data[FLAG_LO +: N_FLAGS]);
      end
   end

   assign reload = reload_q;
   assign delta  = delta_q;
   assign flags  = flags_q;

   // R3: once locked the configuration never moves again
   a_r3_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> ($stable(reload_q) && $stable(delta_q) && $stable(flags_q)));
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
   parameter int unsigned CNT_W = 16,
   parameter logic [CNT_W-1:0] DEF_RELOAD = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             stop,
   input  logic             mode_load,
   input  logic [CNT_W-1:0] new_reload,
   input  logic [CNT_W-1:0] reload,
   input  logic [CNT_W-1:0] delta,
   input  logic             restart_req,
   output logic [CNT_W-1:0] count,
   output logic             early_evt,
   output logic             und_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             step;
   logic             in_window;

   assign step      = tick && !stop && !mode_load;
   assign in_window = (cnt_q <= delta);
   assign early_evt = restart_req && !in_window;
   assign und_evt   = step && !pend_q && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= DEF_RELOAD;
         pend_q <= 1'b0;
      end else if (mode_load) begin
         cnt_q  <= new_reload;
         pend_q <= 1'b0;
      end else begin
         if (step) begin
            if (pend_q)
               cnt_q <= reload;
            else if (cnt_q != '0)
               cnt_q <= cnt_q - ONE;
         end
         if (restart_req && in_window)
            pend_q <= 1'b1;
         else if (step)
            pend_q <= 1'b0;
      end
   end

   assign count = cnt_q;

   // R4: plain step decrements by one
   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !pend_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
   // R7: a pending restart reloads on the tick
   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (step && pend_q) |=> (cnt_q == $past(reload)));
   // R10: stopped counter does not move
   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !mode_load) |=> $stable(cnt_q));
endmodule

// File: rtl/wwdt_fault.sv
module wwdt_fault #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       und_evt,
   input  logic       early_evt,
   input  logic       stat_rd,
   input  logic       irq_en,
   input  logic       rst_en,
   output logic [1:0] stat,
   output logic       irq,
   output logic       rst_req
);
   logic und_q, err_q;
   logic fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         und_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         und_q <= und_evt   || (und_q && !stat_rd);
         err_q <= early_evt || (err_q && !stat_rd);
      end
   end

   assign stat  = {err_q, und_q};
   assign fault = und_q || err_q;

   generate
      if (OUT_REG) begin : g_reg_out
         logic irq_q, rst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
               rst_q <= 1'b0;
            end else begin
               irq_q <= fault && irq_en;
               rst_q <= fault && rst_en;
            end
         end
         assign irq     = irq_q;
         assign rst_req = rst_q;
      end else begin : g_comb_out
         assign irq     = fault && irq_en;
         assign rst_req = fault && rst_en;
      end
   endgenerate

   // R5: underflow event lands in stat[0]
   a_r5_und_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      und_evt |=> stat[0]);
   // R6: early restart lands in stat[1]
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      early_evt |=> stat[1]);
   // R9: read without a new event empties the status
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !und_evt && !early_evt) |=> (stat == 2'b00));
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
   import wwdt_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned ADDR_W  = 2,
   parameter logic [CNT_W-1:0] DEF_RELOAD = '1,
   parameter logic [CNT_W-1:0] DEF_DELTA  = '1,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              tick,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [KEY_W+2*CNT_W+N_FLAGS-1:0]  wr_data,
   input  logic                              stat_rd,
   output logic [CNT_W-1:0]                  count,
   output logic [1:0]                        stat,
   output logic                              irq,
   output logic                              rst_req
);
   initial begin
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
   end

   logic [CNT_W-1:0] reload, delta, new_reload;
   wd_flags_t        flags;
   logic             mode_load, restart_req;
   logic             early_evt, und_evt;

   wwdt_regs #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W),
      .DEF_RELOAD(DEF_RELOAD), .DEF_DELTA(DEF_DELTA)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .reload(reload), .delta(delta), .flags(flags),
      .mode_load(mode_load), .new_reload(new_reload),
      .restart_req(restart_req)
   );

   wwdt_counter #(
      .CNT_W(CNT_W), .DEF_RELOAD(DEF_RELOAD)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stop(flags.stop),
      .mode_load(mode_load), .new_reload(new_reload),
      .reload(reload), .delta(delta), .restart_req(restart_req),
      .count(count), .early_evt(early_evt), .und_evt(und_evt)
   );

   wwdt_fault #(
      .OUT_REG(OUT_REG)
   ) u_fault (
      .clk(clk), .rst_n(rst_n),
      .und_evt(und_evt), .early_evt(early_evt), .stat_rd(stat_rd),
      .irq_en(flags.irq_en), .rst_en(flags.rst_en),
      .stat(stat), .irq(irq), .rst_req(rst_req)
   );
endmodule

// File: tb/wwdt_top_tb_top.sv
module wwdt_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, wr_en = 1'b0, stat_rd = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [42:0] wr_data = '0;
   logic [15:0] count;
   logic [1:0]  stat;
   logic        irq, rst_req;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [15:0] m_cnt, m_rel, m_del;
   logic m_irq, m_rst, m_dis, m_lock, m_pend, m_und, m_err;

   always #4 clk = ~clk;

   wwdt_top dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
      .count(count), .stat(stat), .irq(irq), .rst_req(rst_req)
   );

   function automatic logic [42:0] mk_mode(logic [7:0] k, logic [15:0] rl,
         logic [15:0] dl, logic ie, logic re, logic st);
      return {k, st, re, ie, dl, rl};
   endfunction

   function automatic logic [42:0] mk_ctrl(logic [7:0] k, logic go);
      return {k, 34'd0, go};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic m_reset();
      m_cnt = 16'hFFFF; m_rel = 16'hFFFF; m_del = 16'hFFFF;
      m_irq = 0; m_rst = 1; m_dis = 0; m_lock = 0; m_pend = 0;
      m_und = 0; m_err = 0;
   endtask

   task automatic do_reset();
      rst_n = 0; tick = 0; wr_en = 0; stat_rd = 0; wr_addr = 0; wr_data = 0;
      repeat (3) @(posedge clk);
      #2;
      m_reset();
      chk("R1 count", 32'(count), 32'hFFFF);
      chk("R1 stat", 32'(stat), 0);
      chk("R1 irq/rst_req", 32'({irq, rst_req}), 0);
      rst_n = 1;
   endtask

   // one clock: drive, update model, sample 2 ns after the edge
   task automatic step(logic t, logic w, logic [1:0] a, logic [42:0] d, logic r);
      logic kok, rs, mw, early, good, uev, tk;
      tick = t; wr_en = w; wr_addr = a; wr_data = d; stat_rd = r;
      kok   = (d[42:35] == 8'hA5);
      rs    = w && a == 2'd0 && kok && d[0] && !m_dis;
      mw    = w && a == 2'd1 && kok && !m_lock;
      early = rs && (m_cnt > m_del);
      good  = rs && !early;
      uev   = t && !m_dis && !m_pend && m_cnt == 16'd1 && !mw;
      if (mw) begin
         m_cnt = d[15:0]; m_pend = 0; m_rel = d[15:0]; m_del = d[31:16];
         m_irq = d[32]; m_rst = d[33]; m_dis = d[34]; m_lock = 1;
      end else begin
         tk = t && !m_dis;
         if (tk) begin
            if (m_pend) m_cnt = m_rel;
            else if (m_cnt != 0) m_cnt = m_cnt - 16'd1;
         end
         m_pend = good ? 1'b1 : (tk ? 1'b0 : m_pend);
      end
      m_und = uev || (m_und && !r);
      m_err = early || (m_err && !r);
      @(posedge clk);
      #2;
      chk("R4 count", 32'(count), 32'(m_cnt));
      chk("R9 stat", 32'(stat), 32'({m_err, m_und}));
      chk("R8 irq", 32'(irq), 32'((m_und || m_err) && m_irq));
      chk("R8 rst_req", 32'(rst_req), 32'((m_und || m_err) && m_rst));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0);
   endtask

   task automatic rand_run(int n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] k;
         logic [1:0] a;
         logic [42:0] d;
         k = ($urandom % 4 != 0) ? 8'hA5 : 8'($urandom);
         a = 2'($urandom % 4);
         if (a == 2'd1)
            d = mk_mode(k, 16'(1 + $urandom % 30), 16'($urandom % 32),
                        1'($urandom), 1'($urandom), ($urandom % 8 == 0));
         else
            d = mk_ctrl(k, 1'($urandom));
         step(($urandom % 3 == 0), ($urandom % 6 == 0), a, d, ($urandom % 8 == 0));
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));

      // episode A: keys, write-once, underflow, read, restart window
      do_reset();
      step(1, 1, 2'd1, mk_mode(8'h5A, 16'd5, 16'd2, 1, 0, 0), 0);
      chk("R2 bad-key config ignored", 32'(count), 32'hFFFE);
      step(1, 1, 2'd0, mk_ctrl(8'h00, 1), 0);
      step(1, 0, 0, '0, 0);
      chk("R2 bad-key restart ignored", 32'(count), 32'hFFFC);
      step(0, 1, 2'd1, mk_mode(8'hA5, 16'd4, 16'd2, 1, 0, 0), 0);
      chk("R3 config loads count", 32'(count), 4);
      step(0, 1, 2'd1, mk_mode(8'hA5, 16'd9, 16'd9, 0, 1, 1), 0);
      chk("R3 second config ignored", 32'(count), 4);
      for (int i = 0; i < 4; i++) step(1, 0, 0, '0, 0);
      chk("R5 underflow bit", 32'(stat), 32'b01);
      chk("R8 irq on underflow", 32'({irq, rst_req}), 32'b10);
      step(1, 0, 0, '0, 0);
      chk("R4 holds at zero", 32'(count), 0);
      step(0, 0, 0, '0, 1);
      chk("R9 read clears", 32'(stat), 0);
      step(1, 1, 2'd0, mk_ctrl(8'hA5, 1), 0);
      chk("R7 no reload on same-cycle tick", 32'(count), 0);
      step(1, 0, 0, '0, 0);
      chk("R7 reload on next tick", 32'(count), 4);
      step(0, 1, 2'd0, mk_ctrl(8'hA5, 1), 0);
      chk("R6 early restart error", 32'(stat), 32'b10);
      chk("R6 count unchanged", 32'(count), 4);
      step(0, 0, 0, '0, 1);

      // episode B: read collides with underflow
      do_reset();
      step(0, 1, 2'd1, mk_mode(8'hA5, 16'd2, 16'd5, 0, 1, 0), 0);
      step(1, 0, 0, '0, 0);
      step(1, 0, 0, '0, 1);
      chk("R9 set wins over clear", 32'(stat), 32'b01);
      chk("R8 reset request", 32'(rst_req), 1);

      // episode C: stopped
      do_reset();
      step(0, 1, 2'd1, mk_mode(8'hA5, 16'd7, 16'd1, 1, 1, 1), 0);
      for (int i = 0; i < 5; i++) step(1, 0, 0, '0, 0);
      chk("R10 frozen count", 32'(count), 7);
      step(1, 1, 2'd0, mk_ctrl(8'hA5, 1), 0);
      idle(2);
      chk("R10 restart ignored", 32'(stat), 0);

      // random episodes
      for (int e = 0; e < 20; e++) begin
         do_reset();
         rand_run(400);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule